// File: doc/BRIEF.md
# Wake-Up and Kickstart Power Controller

This block decides when to switch the main system supply on while that supply is absent. It has two possible sources. The first is a one-cycle alarm-match strobe from the clock core. The second is an asynchronous, active-low kickstart input, such as a push button. Each source has its own enable. A source is honoured only while the main-supply-present indication is low. When an enabled source is honoured, the block drives its active-low power-on output and sets a sticky flag that records the cause.

A small host register port gives access to two 8-bit registers. The flag register holds the wake flag and the kickstart flag. The host clears each flag by writing 0 to its bit. The control register holds the two source enables, a RAM-clear enable and the power-hold bit. The power-hold bit reads back the state of the power-on output, and writing 0 to it releases the supply.

The block also has a RAM-clear input. When the RAM-clear enable is set and that input is held low, the block raises a RAM-erase request.

Top module: `wkp_power_ctrl`

## Requirements
- R1: While `main_pwr_ok` is 0 and the wake enable (control bit 0) is 1, an `alarm_match` pulse sets the wake flag (flag bit 0) and drives `pwr_on_n` low on the next clock edge.
- R2: `kick_n` passes through a two-flop synchronizer. A falling edge, while `main_pwr_ok` is 0 and the kickstart enable (control bit 1) is 1, sets the kickstart flag (flag bit 1) and drives `pwr_on_n` low. A level that stays low does not fire again.
- R3: While `main_pwr_ok` is 1, alarm and kickstart events set no flag and leave `pwr_on_n` unchanged.
- R4: When the enable of a source is 0, events from that source set no flag and leave `pwr_on_n` unchanged.
- R5: Each flag stays set until the host writes 0 to its bit in the flag register (`reg_sel`=0). Writing 1 has no effect. An event in the same cycle as the clearing write leaves the flag set.
- R6: Control bit 3 reads 1 exactly while `pwr_on_n` is low. Writing 0 to it releases `pwr_on_n` high, and writing 1 to it has no effect. An event in the same cycle as the releasing write keeps `pwr_on_n` low.
- R7: Once `pwr_on_n` is low, it stays low when `main_pwr_ok` later rises or falls again.
- R8: With the RAM-clear enable (control bit 2) set, a low level on `rclr_n`, after two synchronizer flops, sets `ram_erase` high. With the enable clear, `ram_erase` stays low.
- R9: After reset, both registers read 0 and `pwr_on_n` is high. Control bits 0 to 2 read back the value last written, and unused bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| main_pwr_ok | input | 1 | Main supply present |
| alarm_match | input | 1 | One-cycle alarm-match strobe from the clock core |
| kick_n | input | 1 | Asynchronous active-low kickstart input |
| rclr_n | input | 1 | Asynchronous active-low RAM-clear input |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | Register select: 0 = flags, 1 = control |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the selected register |
| pwr_on_n | output | 1 | Active-low power-on request |
| ram_erase | output | 1 | RAM-erase request |

## Verification
A host write and a source event can land in the same clock cycle. There are two such collisions: a write that clears a flag against a new alarm, and a write that releases power-hold against a new alarm. The bench provokes both by driving `reg_wr` and `alarm_match` in the same low clock phase. In each case it expects the event to win, so the flag reads 1 and `pwr_on_n` stays low. Outside these collisions, the bench sweeps supply state, enable and source over all combinations and predicts the flag and output arithmetically as `!main & enable`.

// File: rtl/wkp_pkg.sv
package wkp_pkg;
    localparam int REG_W    = 8;
    localparam int FLG_WAKE = 0;
    localparam int FLG_KICK = 1;
    localparam int EN_WAKE  = 0;
    localparam int EN_KICK  = 1;
    localparam int EN_RCLR  = 2;
    localparam int EN_PWR   = 3;

    typedef struct packed {
        logic wf;
        logic kf;
        logic wake_en;
        logic kick_en;
        logic rclr_en;
        logic pwr_on;
        logic erase;
    } wkp_state_t;
endpackage

// File: rtl/wkp_sync_fall.sv
module wkp_sync_fall #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din_n,
    output logic level_low,
    output logic fall
);
    localparam int W = STAGES + 1;

    logic [W-1:0] sh_q, sh_d;

    always_comb begin
        sh_d = {sh_q[W-2:0], din_n};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '1;
        else        sh_q <= sh_d;
    end

    assign level_low = ~sh_q[STAGES-1];
    assign fall      = sh_q[STAGES] & ~sh_q[STAGES-1];

    AST_FALL_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        fall |=> !fall); // R2
endmodule

// File: rtl/wkp_src_qual.sv
module wkp_src_qual (
    input  logic main_ok,
    input  logic alarm,
    input  logic kick_fall,
    input  logic wake_en,
    input  logic kick_en,
    output logic wake_evt,
    output logic kick_evt
);
    always_comb begin
        wake_evt = alarm     & wake_en & ~main_ok;
        kick_evt = kick_fall & kick_en & ~main_ok;
    end
endmodule

// File: rtl/wkp_power_ctrl.sv
module wkp_power_ctrl
    import wkp_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             main_pwr_ok,
    input  logic             alarm_match,
    input  logic             kick_n,
    input  logic             rclr_n,
    input  logic             reg_wr,
    input  logic             reg_sel,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    output logic             pwr_on_n,
    output logic             ram_erase
);
    wkp_state_t st_q, st_d;
    logic kick_low, kick_fall, rclr_low, rclr_fall;
    logic wake_evt, kick_evt;
    logic wr_flg, wr_ctl;
    logic wf_q, kf_q;

    wkp_sync_fall #(.STAGES(SYNC_STAGES)) u_kick_sync (
        .clk(clk), .rst_n(rst_n), .din_n(kick_n),
        .level_low(kick_low), .fall(kick_fall));

    wkp_sync_fall #(.STAGES(SYNC_STAGES)) u_rclr_sync (
        .clk(clk), .rst_n(rst_n), .din_n(rclr_n),
        .level_low(rclr_low), .fall(rclr_fall));

    wkp_src_qual u_qual (
        .main_ok(main_pwr_ok), .alarm(alarm_match), .kick_fall(kick_fall),
        .wake_en(st_q.wake_en), .kick_en(st_q.kick_en),
        .wake_evt(wake_evt), .kick_evt(kick_evt));

    always_comb begin
        st_d   = st_q;
        wr_flg = reg_wr & ~reg_sel;
        wr_ctl = reg_wr &  reg_sel;
        if (wr_flg) begin
            st_d.wf = st_q.wf & reg_wdata[FLG_WAKE];
            st_d.kf = st_q.kf & reg_wdata[FLG_KICK];
        end
        if (wr_ctl) begin
            st_d.wake_en = reg_wdata[EN_WAKE];
            st_d.kick_en = reg_wdata[EN_KICK];
            st_d.rclr_en = reg_wdata[EN_RCLR];
            if (!reg_wdata[EN_PWR]) st_d.pwr_on = 1'b0;
        end
        if (wake_evt) begin
            st_d.wf     = 1'b1;
            st_d.pwr_on = 1'b1;
        end
        if (kick_evt) begin
            st_d.kf     = 1'b1;
            st_d.pwr_on = 1'b1;
        end
        st_d.erase = st_q.rclr_en & rclr_low;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        reg_rdata = '0;
        if (reg_sel) begin
            reg_rdata[EN_WAKE] = st_q.wake_en;
            reg_rdata[EN_KICK] = st_q.kick_en;
            reg_rdata[EN_RCLR] = st_q.rclr_en;
            reg_rdata[EN_PWR]  = st_q.pwr_on;
        end else begin
            reg_rdata[FLG_WAKE] = st_q.wf;
            reg_rdata[FLG_KICK] = st_q.kf;
        end
    end

    assign pwr_on_n  = ~st_q.pwr_on;
    assign ram_erase = st_q.erase;
    assign wf_q      = st_q.wf;
    assign kf_q      = st_q.kf;

    AST_WAKE_POWERS: assert property (@(posedge clk) disable iff (!rst_n)
        (alarm_match && !main_pwr_ok && st_q.wake_en) |=> (wf_q && !pwr_on_n)); // R1
    AST_KICK_POWERS: assert property (@(posedge clk) disable iff (!rst_n)
        (kick_fall && !main_pwr_ok && st_q.kick_en) |=> (kf_q && !pwr_on_n)); // R2
    AST_MAIN_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (main_pwr_ok && !reg_wr) |=> ($stable(pwr_on_n) && $stable(wf_q) && $stable(kf_q))); // R3
    AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.wake_en && !st_q.kick_en && !reg_wr) |=> $stable(pwr_on_n)); // R4
    AST_WF_HOST_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wf_q) |-> $past(reg_wr && !reg_sel && !reg_wdata[FLG_WAKE])); // R5
    AST_KF_HOST_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(kf_q) |-> $past(reg_wr && !reg_sel && !reg_wdata[FLG_KICK])); // R5
    AST_RELEASE_BY_HOST: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pwr_on_n) |-> $past(reg_wr && reg_sel && !reg_wdata[EN_PWR])); // R6
endmodule

// File: tb/tb_wkp_power_ctrl.sv
module tb_wkp_power_ctrl;
    logic clk = 0, rst_n = 0;
    logic main_pwr_ok = 0, alarm_match = 0, kick_n = 1, rclr_n = 1;
    logic reg_wr = 0, reg_sel = 0;
    logic [7:0] reg_wdata = 0, reg_rdata;
    logic pwr_on_n, ram_erase;
    int n_chk = 0, n_bad = 0;
    bit done = 0;
    logic [7:0] rv;

    always #10 clk = ~clk;

    wkp_power_ctrl dut (.*);

    task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic sel, input logic [7:0] d);
        @(negedge clk); reg_wr = 1; reg_sel = sel; reg_wdata = d;
        @(negedge clk); reg_wr = 0;
    endtask

    task automatic rd(input logic sel, output logic [7:0] d);
        @(negedge clk); reg_sel = sel; #1 d = reg_rdata;
    endtask

    task automatic do_reset();
        rst_n = 0; main_pwr_ok = 0; alarm_match = 0; kick_n = 1; rclr_n = 1; reg_wr = 0;
        repeat (2) @(negedge clk); rst_n = 1;
    endtask

    task automatic pulse_alarm();
        @(negedge clk); alarm_match = 1; @(negedge clk); alarm_match = 0;
    endtask

    task automatic press_kick();
        @(negedge clk); kick_n = 0; repeat (3) @(negedge clk); kick_n = 1;
        repeat (4) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++; n_chk++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        do_reset();
        rd(0, rv); check("R9 reset flags", rv, 8'h00);
        rd(1, rv); check("R9 reset ctrl", rv, 8'h00);
        check("R9 reset pwr_on_n", {7'b0, pwr_on_n}, 8'h01);
        wr(1, 8'hF7);
        rd(1, rv); check("R9 ctrl readback unused zero", rv, 8'h07);

        // Sweep: main x enable x source -> R1 R2 R3 R4
        for (int m = 0; m < 2; m++)
            for (int e = 0; e < 2; e++)
                for (int s = 0; s < 2; s++) begin
                    logic exp;
                    do_reset();
                    wr(1, s ? {6'b0, e[0], 1'b0} : {7'b0, e[0]});
                    @(negedge clk); main_pwr_ok = m[0];
                    if (s) press_kick(); else begin pulse_alarm(); repeat (2) @(negedge clk); end
                    exp = !m[0] && e[0];
                    rd(0, rv);
                    check(s ? (m ? "R3 kick flag" : (e ? "R2 kick flag" : "R4 kick flag"))
                            : (m ? "R3 wake flag" : (e ? "R1 wake flag" : "R4 wake flag")),
                          rv, s ? {6'b0, exp, 1'b0} : {7'b0, exp});
                    check(s ? "R2/R3/R4 kick pwr" : "R1/R3/R4 wake pwr",
                          {7'b0, pwr_on_n}, {7'b0, !exp});
                end

        // R2: held-low level does not retrigger after clear
        do_reset();
        wr(1, 8'h02);
        @(negedge clk); kick_n = 0; repeat (5) @(negedge clk);
        wr(0, 8'h00);
        repeat (5) @(negedge clk);
        rd(0, rv); check("R2 held low no retrigger", rv, 8'h00);
        kick_n = 1; repeat (4) @(negedge clk);

        // R5 sticky, write 1 no effect, write 0 clears
        do_reset();
        wr(1, 8'h01);
        pulse_alarm();
        wr(0, 8'hFF);
        rd(0, rv); check("R5 write1 no effect", rv, 8'h01);
        wr(0, 8'h00);
        rd(0, rv); check("R5 write0 clears", rv, 8'h00);
        pulse_alarm();
        // R5 collision: clear and event same cycle
        @(negedge clk); reg_wr = 1; reg_sel = 0; reg_wdata = 8'h00; alarm_match = 1;
        @(negedge clk); reg_wr = 0; alarm_match = 0;
        rd(0, rv); check("R5 event beats clear", rv, 8'h01);

        // R6 power-hold readback, write1 no effect, write0 releases
        rd(1, rv); check("R6 hold reads 1", rv, 8'h09);
        wr(1, 8'h09);
        check("R6 write1 keeps on", {7'b0, pwr_on_n}, 8'h00);
        @(negedge clk); reg_wr = 1; reg_sel = 1; reg_wdata = 8'h01; alarm_match = 1;
        @(negedge clk); reg_wr = 0; alarm_match = 0;
        check("R6 event beats release", {7'b0, pwr_on_n}, 8'h00);
        wr(1, 8'h01);
        check("R6 write0 releases", {7'b0, pwr_on_n}, 8'h01);
        rd(1, rv); check("R6 hold reads 0", rv, 8'h01);

        // R7 output survives supply transitions
        pulse_alarm();
        @(negedge clk); main_pwr_ok = 1; repeat (3) @(negedge clk);
        check("R7 main rises keeps on", {7'b0, pwr_on_n}, 8'h00);
        main_pwr_ok = 0; repeat (3) @(negedge clk);
        check("R7 main falls keeps on", {7'b0, pwr_on_n}, 8'h00);

        // R8 RAM clear gated by enable
        do_reset();
        @(negedge clk); rclr_n = 0; repeat (4) @(negedge clk);
        check("R8 disabled no erase", {7'b0, ram_erase}, 8'h00);
        wr(1, 8'h04); repeat (2) @(negedge clk);
        check("R8 enabled erase", {7'b0, ram_erase}, 8'h01);
        rclr_n = 1; repeat (4) @(negedge clk);
        check("R8 released", {7'b0, ram_erase}, 8'h00);

        finish_run();
    end
endmodule